// File: doc/BRIEF.md
# Branch Next-Address Unit

This block works out where instruction flow goes after a branch. It holds the program counter and, for each branch it is handed, returns the next address, a taken flag, and write requests for the count and link registers. It supports four branch kinds: an unconditional branch with a long displacement, a conditional branch with a short displacement, a conditional branch to the count register, and a conditional branch to the link register.

The option field sets up two tests. The first is a count test. It can decrement the count register first and then check whether the result is zero. The second is a condition test, which compares one selected bit of the condition register against an expected polarity. Either test can be switched off. A conditional branch is taken only when both tests pass. The link register can be loaded with the return address whether or not the branch is taken.

The caller presents a branch with a one-cycle `br_valid_i` strobe together with the current condition, count and link register values. There is no back-pressure: a branch is accepted on every clock edge where the strobe is high. The program counter, taken flag and both register write requests are all updated on that same edge. The write requests are single-cycle pulses. They are meant to be applied to the count and link registers before the next branch is presented.

Top module: `bru_next_addr`

## Requirements
- R1: After reset, `pc_o` equals the `RESET_PC` parameter, and `taken_o`, `ctr_we_o` and `lr_we_o` are 0.
- R2: A clock edge with `br_valid_i` low leaves `pc_o` unchanged and drives `taken_o`, `ctr_we_o` and `lr_we_o` to 0, whatever the other inputs are.
- R3: For branch kinds 1, 2 and 3 with option bit 2 (`bo_i[2]`, weight 0x04) clear, `ctr_we_o` pulses and `ctr_o` = `ctr_i` - 1, wrapping from 0 to all ones. When that bit is set, or for kind 0, no count write happens.
- R4: The count test passes when `bo_i[2]` is set. Otherwise it passes when "count register after the decrement equals zero" matches `bo_i[1]` (weight 0x02).
- R5: The condition test passes when `bo_i[4]` (weight 0x10) is set. Otherwise it passes when bit `31 - bi_i` of `cr_i` equals `bo_i[3]` (weight 0x08), so `bi_i` = 0 selects `cr_i[31]`.
- R6: A conditional kind is taken only when both the count test and the condition test pass. A branch that is not taken sets `pc_o` to the old `pc_o` + 4 and `taken_o` to 0.
- R7: Displacement targets are the sign-extended offset shifted left by 2. Kind 0 uses all 24 bits of `disp_i`; kind 1 uses `disp_i[13:0]`. With `aa_i` = 1 the target is this value as an absolute address; with `aa_i` = 0 it is added to the old `pc_o`.
- R8: Kind 2 targets the count value after any decrement, with its two low bits cleared. Kind 3 targets `lr_i` with its two low bits cleared, using the incoming `lr_i` even when a link write occurs on the same edge. `aa_i` is ignored for both kinds.
- R9: With `lk_i` = 1, `lr_we_o` pulses and `lr_o` = old `pc_o` + 4, whether or not the branch is taken. With `lk_i` = 0 there is no link write.
- R10: Kind 0 (unconditional) is always taken, regardless of `bo_i`, `bi_i` and `cr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch strobe; one branch per high cycle |
| br_kind_i | input | 2 | 0 unconditional, 1 conditional displacement, 2 to count register, 3 to link register |
| bo_i | input | 5 | Branch option field |
| bi_i | input | 5 | Condition bit index, counted from the MSB |
| disp_i | input | 24 | Word displacement (kind 1 uses the low 14 bits) |
| aa_i | input | 1 | Absolute-address flag |
| lk_i | input | 1 | Link flag |
| cr_i | input | 32 | Condition register value |
| ctr_i | input | 32 | Count register value |
| lr_i | input | 32 | Link register value |
| pc_o | output | 32 | Program counter |
| taken_o | output | 1 | Last branch was taken |
| ctr_o | output | 32 | New count register value |
| ctr_we_o | output | 1 | Count register write pulse |
| lr_o | output | 32 | New link register value |
| lr_we_o | output | 1 | Link register write pulse |

## Verification
The bench builds the unit with its default 32-bit width and a non-zero `RESET_PC` of 0x1000. This lets reset be told apart from a branch to zero and makes relative targets visibly depend on the held program counter. With a 32-bit condition register, both ends of the bit index (0 and 31) can be exercised. The 24-bit and 14-bit displacement widths allow negative offsets and absolute targets, and the 32-bit count register allows the decrement to wrap from 0 to all ones.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BK_UNCOND = 2'd0,
    BK_DISP   = 2'd1,
    BK_CTR    = 2'd2,
    BK_LR     = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic dec_en;
    logic cnt_ok;
    logic cond_ok;
  } br_dec_t;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BI_W = 5,
  localparam int CR_W = 1 << BI_W
) (
  input  logic            cond_kind_i,
  input  logic [4:0]      bo_i,
  input  logic [BI_W-1:0] bi_i,
  input  logic [CR_W-1:0] cr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] ctr_next_o,
  output br_dec_t         dec_o
);
  logic [BI_W-1:0] sel_idx;
  logic            cr_bit;

  always_comb begin
    // bit index counts from the MSB of the condition register
    sel_idx         = BI_W'(CR_W - 1) - bi_i;
    cr_bit          = cr_i[sel_idx];
    dec_o.dec_en    = cond_kind_i && !bo_i[2];
    ctr_next_o      = dec_o.dec_en ? ctr_i - XLEN'(1) : ctr_i;
    dec_o.cnt_ok    = bo_i[2] || ((ctr_next_o == '0) == bo_i[1]);
    dec_o.cond_ok   = bo_i[4] || (cr_bit == bo_i[3]);
  end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen
  import bru_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LI_W = 24,
  parameter int BD_W = 14
) (
  input  br_kind_e        kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [LI_W-1:0] disp_i,
  input  logic            aa_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  output logic [XLEN-1:0] tgt_o
);
  logic [XLEN-1:0] off_long;
  logic [XLEN-1:0] off_short;
  logic [XLEN-1:0] off_sel;

  always_comb begin
    off_long  = {{(XLEN-LI_W-2){disp_i[LI_W-1]}}, disp_i, 2'b00};
    off_short = {{(XLEN-BD_W-2){disp_i[BD_W-1]}}, disp_i[BD_W-1:0], 2'b00};
    off_sel   = (kind_i == BK_UNCOND) ? off_long : off_short;
    unique case (kind_i)
      BK_CTR:  tgt_o = {ctr_i[XLEN-1:2], 2'b00};
      BK_LR:   tgt_o = {lr_i[XLEN-1:2], 2'b00};
      default: tgt_o = aa_i ? off_sel : pc_i + off_sel;
    endcase
  end
endmodule

// File: rtl/bru_next_addr.sv
module bru_next_addr
  import bru_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              LI_W     = 24,
  parameter int              BD_W     = 14,
  parameter int              BI_W     = 5,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  localparam int             CR_W     = 1 << BI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            br_valid_i,
  input  logic [1:0]      br_kind_i,
  input  logic [4:0]      bo_i,
  input  logic [BI_W-1:0] bi_i,
  input  logic [LI_W-1:0] disp_i,
  input  logic            aa_i,
  input  logic            lk_i,
  input  logic [CR_W-1:0] cr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  output logic [XLEN-1:0] pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] ctr_o,
  output logic            ctr_we_o,
  output logic [XLEN-1:0] lr_o,
  output logic            lr_we_o
);
  br_kind_e        kind;
  br_dec_t         dec;
  logic [XLEN-1:0] ctr_next;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq_pc;
  logic            take;

  assign kind   = br_kind_e'(br_kind_i);
  assign seq_pc = pc_o + XLEN'(4);

  bru_cond_eval #(.XLEN(XLEN), .BI_W(BI_W)) u_cond (
    .cond_kind_i (kind != BK_UNCOND),
    .bo_i        (bo_i),
    .bi_i        (bi_i),
    .cr_i        (cr_i),
    .ctr_i       (ctr_i),
    .ctr_next_o  (ctr_next),
    .dec_o       (dec)
  );

  bru_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .kind_i (kind),
    .pc_i   (pc_o),
    .disp_i (disp_i),
    .aa_i   (aa_i),
    .ctr_i  (ctr_next),
    .lr_i   (lr_i),
    .tgt_o  (tgt)
  );

  assign take = (kind == BK_UNCOND) || (dec.cnt_ok && dec.cond_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= RESET_PC;
      taken_o  <= 1'b0;
      ctr_o    <= '0;
      ctr_we_o <= 1'b0;
      lr_o     <= '0;
      lr_we_o  <= 1'b0;
    end else begin
      taken_o  <= br_valid_i && take;
      ctr_we_o <= br_valid_i && dec.dec_en;
      lr_we_o  <= br_valid_i && lk_i;
      if (br_valid_i) begin
        pc_o  <= take ? tgt : seq_pc;
        ctr_o <= ctr_next;
        lr_o  <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/bru_next_addr_chk.sv
module bru_next_addr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            br_valid_i,
  input logic [1:0]      br_kind_i,
  input logic [4:0]      bo_i,
  input logic            lk_i,
  input logic [XLEN-1:0] ctr_i,
  input logic [XLEN-1:0] pc_o,
  input logic            taken_o,
  input logic [XLEN-1:0] ctr_o,
  input logic            ctr_we_o,
  input logic [XLEN-1:0] lr_o,
  input logic            lr_we_o
);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> (!taken_o && !ctr_we_o && !lr_we_o && pc_o == $past(pc_o)));

  a_r3_ctr_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && br_kind_i != 2'd0 && !bo_i[2])
      |=> (ctr_we_o && ctr_o == $past(ctr_i) - XLEN'(1)));

  a_r3_no_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && (br_kind_i == 2'd0 || bo_i[2])) |=> !ctr_we_o);

  a_r6_fallthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |=> (taken_o || pc_o == $past(pc_o) + XLEN'(4)));

  a_r9_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && lk_i) |=> (lr_we_o && lr_o == $past(pc_o) + XLEN'(4)));

  a_r10_uncond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && br_kind_i == 2'd0) |=> taken_o);
endmodule

bind bru_next_addr bru_next_addr_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .br_valid_i (br_valid_i),
  .br_kind_i  (br_kind_i),
  .bo_i       (bo_i),
  .lk_i       (lk_i),
  .ctr_i      (ctr_i),
  .pc_o       (pc_o),
  .taken_o    (taken_o),
  .ctr_o      (ctr_o),
  .ctr_we_o   (ctr_we_o),
  .lr_o       (lr_o),
  .lr_we_o    (lr_we_o)
);

// File: tb/bru_next_addr_bench.sv
module bru_next_addr_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  typedef struct packed {
    logic [1:0]  k;
    logic [4:0]  bo;
    logic [4:0]  bi;
    logic [23:0] d;
    logic        aa;
    logic        lk;
    logic [31:0] cr;
    logic [31:0] ctr;
    logic [31:0] lr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'h00, 5'd0,  24'h000010, 1'b0, 1'b0, 32'h0,         32'h0,         32'h0},
    '{2'd0, 5'h00, 5'd0,  24'hFFFFFC, 1'b1, 1'b1, 32'h0,         32'h0,         32'h0},
    '{2'd1, 5'h0C, 5'd0,  24'h003FFE, 1'b0, 1'b0, 32'h8000_0000, 32'h7,         32'h0},
    '{2'd1, 5'h0C, 5'd0,  24'h003FFE, 1'b0, 1'b0, 32'h0,         32'h7,         32'h0},
    '{2'd1, 5'h04, 5'd31, 24'h000020, 1'b1, 1'b0, 32'h0,         32'h7,         32'h0},
    '{2'd1, 5'h10, 5'd0,  24'h000004, 1'b0, 1'b0, 32'h0,         32'h5,         32'h0},
    '{2'd1, 5'h12, 5'd0,  24'h000008, 1'b0, 1'b0, 32'h0,         32'h1,         32'h0},
    '{2'd1, 5'h12, 5'd0,  24'h000008, 1'b0, 1'b0, 32'h0,         32'h2,         32'h0},
    '{2'd1, 5'h10, 5'd0,  24'h000100, 1'b1, 1'b0, 32'h0,         32'h0,         32'h0},
    '{2'd2, 5'h14, 5'd0,  24'h000000, 1'b1, 1'b1, 32'h0,         32'h2003,      32'h0},
    '{2'd3, 5'h14, 5'd0,  24'h000000, 1'b0, 1'b1, 32'h0,         32'h0,         32'h3007},
    '{2'd3, 5'h0C, 5'd5,  24'h000000, 1'b0, 1'b1, 32'hFBFF_FFFF, 32'h0,         32'h5000},
    '{2'd2, 5'h10, 5'd0,  24'h000000, 1'b0, 1'b0, 32'h0,         32'h4009,      32'h0},
    '{2'd0, 5'h00, 5'd9,  24'h000040, 1'b1, 1'b0, 32'h0,         32'h0,         32'h0},
    '{2'd1, 5'h00, 5'd3,  24'h000010, 1'b0, 1'b0, 32'h0,         32'h1,         32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  kind = '0;
  logic [4:0]  bo = '0;
  logic [4:0]  bi = '0;
  logic [23:0] disp = '0;
  logic        aa = 1'b0;
  logic        lk = 1'b0;
  logic [31:0] cr = '0;
  logic [31:0] ctr = '0;
  logic [31:0] lr = '0;
  logic [31:0] pc_o, ctr_o, lr_o;
  logic        taken_o, ctr_we_o, lr_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_pc = RST_PC;

  always #5 clk = ~clk;

  bru_next_addr #(.RESET_PC(RST_PC)) u_bru_next_addr (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(valid), .br_kind_i(kind),
    .bo_i(bo), .bi_i(bi), .disp_i(disp), .aa_i(aa), .lk_i(lk),
    .cr_i(cr), .ctr_i(ctr), .lr_i(lr),
    .pc_o(pc_o), .taken_o(taken_o), .ctr_o(ctr_o), .ctr_we_o(ctr_we_o),
    .lr_o(lr_o), .lr_we_o(lr_we_o)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] off, ctr_n, tgt, e_pc;
    logic dec, cnt_ok, cnd_ok, tk;
    @(negedge clk);
    kind = v.k; bo = v.bo; bi = v.bi; disp = v.d; aa = v.aa; lk = v.lk;
    cr = v.cr; ctr = v.ctr; lr = v.lr; valid = 1'b1;
    // expected values from R3..R10
    dec    = (v.k != 2'd0) && !v.bo[2];
    ctr_n  = dec ? v.ctr - 32'd1 : v.ctr;
    cnt_ok = v.bo[2] || ((ctr_n == 32'd0) == v.bo[1]);
    cnd_ok = v.bo[4] || (v.cr[31 - v.bi] == v.bo[3]);
    tk     = (v.k == 2'd0) || (cnt_ok && cnd_ok);
    off    = (v.k == 2'd0) ? {{6{v.d[23]}}, v.d, 2'b00} : {{16{v.d[13]}}, v.d[13:0], 2'b00};
    case (v.k)
      2'd2:    tgt = {ctr_n[31:2], 2'b00};
      2'd3:    tgt = {v.lr[31:2], 2'b00};
      default: tgt = v.aa ? off : exp_pc + off;
    endcase
    e_pc = tk ? tgt : exp_pc + 32'd4;
    @(posedge clk); #1;
    check($sformatf("R6/R7/R8 vec%0d pc", idx), pc_o, e_pc);
    check($sformatf("R4/R5/R10 vec%0d taken", idx), {31'b0, taken_o}, {31'b0, tk});
    check($sformatf("R3 vec%0d ctr_we", idx), {31'b0, ctr_we_o}, {31'b0, dec});
    if (dec) check($sformatf("R3 vec%0d ctr", idx), ctr_o, ctr_n);
    check($sformatf("R9 vec%0d lr_we", idx), {31'b0, lr_we_o}, {31'b0, v.lk});
    if (v.lk) check($sformatf("R9 vec%0d lr", idx), lr_o, exp_pc + 32'd4);
    exp_pc = e_pc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset pc", pc_o, RST_PC);
    check("R1 reset flags", {29'b0, taken_o, ctr_we_o, lr_we_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 pc after release", pc_o, RST_PC);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R2: idle edges ignore all other inputs
    @(negedge clk);
    valid = 1'b0; kind = 2'd0; aa = 1'b1; lk = 1'b1; disp = 24'h000123;
    bo = 5'h04; ctr = 32'h55; lr = 32'h9990;
    @(posedge clk); #1;
    check("R2 idle pc", pc_o, exp_pc);
    check("R2 idle flags", {29'b0, taken_o, ctr_we_o, lr_we_o}, 32'h0);
    @(negedge clk); kind = 2'd3; bo = 5'h00;
    @(posedge clk); #1;
    check("R2 idle pc second", pc_o, exp_pc);
    check("R2 idle flags second", {29'b0, taken_o, ctr_we_o, lr_we_o}, 32'h0);

    // R3: decrement wraps from zero; combined with branch to count register
    run_vec('{2'd2, 5'h10, 5'd0, 24'h0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0}, 100);
    // R8: link form uses incoming link value while also linking
    run_vec('{2'd3, 5'h14, 5'd0, 24'h0, 1'b1, 1'b1, 32'h0, 32'h0, 32'h0000_0ABE}, 101);
    check("R8 link target old value", pc_o, 32'h0000_0ABC);

    // R1: reset in mid-run returns to the vector
    @(negedge clk); valid = 1'b0; rst_n = 1'b0;
    #1;
    check("R1 mid-run reset pc", pc_o, RST_PC);
    check("R1 mid-run reset flags", {29'b0, taken_o, ctr_we_o, lr_we_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    exp_pc = RST_PC;
    run_vec('{2'd1, 5'h0C, 5'd31, 24'h000002, 1'b0, 1'b0, 32'h0000_0001, 32'h0, 32'h0}, 102);

    finish_run();
  end
endmodule